// File: doc/BRIEF.md
# Crystal Oscillator Startup and Clock-Select Controller

This block decides when a high-frequency crystal oscillator is powered and when the main clock multiplexer is moved onto it. Startup can come from four sources: a software enable, a start-only policy, a start-and-select-now policy, or a select-when-ready policy armed by a wake-up pulse from a radio controller. All sources act only while the chip is in an active energy mode. Dropping to deep sleep, or clearing every source, powers the oscillator down and returns the clock selection to the default internal oscillator.

Readiness is not measured from the analog circuit. Once the oscillator enable is seen in the low-frequency domain, a counter waits a programmable number of low-frequency cycles and then raises a ready flag. The flag is carried back into the high-frequency domain through a two-flop synchronizer before it can affect the select or stall outputs. The wait length comes from a 3-bit code that maps onto a nonlinear table.

Top module: `xosc_startup_ctrl`

## Requirements
- R1: `ctrl_word[2:0]` holds a timeout code; codes 0..7 give L = 0, 2, 4, 16, 32, 64, 1024, 4096 low-frequency cycles. `osc_rdy` is first high in the low-frequency period that follows the (L+3)-th rising `lf_clk` edge after `osc_en` rises. The extra 3 edges are the two-flop enable synchronizer plus the ready register.
- R2: Code 0 adds no counted wait, so `osc_rdy` follows the 3rd rising `lf_clk` edge after `osc_en` rises.
- R3: The timeout code must stay constant while `osc_en` is high. It is changed only while the oscillator is off.
- R4: Start-only (`ctrl_word[3]`) in active mode raises `osc_en` one `hf_clk` cycle later. `clk_sel` and `clk_stall` stay 0, both before and after ready.
- R5: Select-now (`ctrl_word[4]`) in active mode raises `osc_en`, `clk_sel` and `clk_stall` one cycle later. `clk_stall` falls one cycle after `osc_rdy` rises, and `clk_sel` stays 1.
- R6: With select-when-ready (`ctrl_word[5]`) set, a one-cycle `wake_evt` pulse in active mode latches a request that raises `osc_en` one cycle later. `clk_sel` rises one cycle after `osc_rdy` and `clk_stall` stays 0. A `wake_evt` pulse while this bit is clear has no effect.
- R7: Software enable (`ctrl_word[6]`) in active mode raises `osc_en` only. `clk_sel` and `clk_stall` stay 0.
- R8: When `active_mode` is 0, or no source is set, `osc_en`, `osc_rdy`, `clk_sel` and `clk_stall` are all 0 one cycle later, and a latched wake request is dropped.
- R9: When several sources are set, select-now wins over select-when-ready, which wins over start-only, which wins over software enable.
- R10: `ctrl_word[7]` is reserved and has no effect on any output.
- R11: The source bits may change at any time. The outputs follow the new winning policy one cycle later, without losing an already reached ready state.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hf_clk | input | 1 | High-frequency domain clock |
| lf_clk | input | 1 | Low-frequency timeout clock |
| rst | input | 1 | Synchronous active-high reset, held across at least two `lf_clk` edges |
| ctrl_word | input | 8 | [7] reserved, [6] software enable, [5] select-when-ready, [4] select-now, [3] start-only, [2:0] timeout code |
| active_mode | input | 1 | 1 = active energy mode, 0 = deep sleep |
| wake_evt | input | 1 | One-cycle wake-up pulse from the radio controller |
| osc_en | output | 1 | Oscillator power enable |
| osc_rdy | output | 1 | Oscillator ready, in the `hf_clk` domain |
| clk_sel | output | 1 | 1 = main clock taken from the crystal oscillator |
| clk_stall | output | 1 | Hold the high-frequency source clock until ready |

## Verification
The assertions assume that the timeout code is frozen whenever the oscillator is enabled. They also assume that the enable is never dropped and raised again before the low-frequency side has seen it fall, because a brief blip could let an earlier count run on. The stimulus changes the timeout code only after the oscillator is off and a settling gap of eight low-frequency periods has passed. It keeps every `lf_clk` edge clear of the `hf_clk` rising edges, so each ready latency can be predicted to the exact low-frequency edge.

// File: rtl/xosc_pkg.sv
package xosc_pkg;

    localparam int CODE_W      = 3;
    localparam int CNT_W       = 13;
    localparam int SYNC_STAGES = 2;
    localparam int CTRL_W      = 8;

    typedef enum logic [2:0] {
        XM_OFF     = 3'd0,
        XM_SW      = 3'd1,
        XM_START   = 3'd2,
        XM_SEL_RDY = 3'd3,
        XM_SEL_NOW = 3'd4
    } xosc_mode_t;

    typedef struct packed {
        logic              rsvd;
        logic              sw_en;
        logic              wake_sel;
        logic              sel_now;
        logic              start_only;
        logic [CODE_W-1:0] tmo;
    } xosc_ctrl_t;

    function automatic logic [CNT_W-1:0] tmo_cycles(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] v;
        case (code)
            3'd0:    v = CNT_W'(0);
            3'd1:    v = CNT_W'(2);
            3'd2:    v = CNT_W'(4);
            3'd3:    v = CNT_W'(16);
            3'd4:    v = CNT_W'(32);
            3'd5:    v = CNT_W'(64);
            3'd6:    v = CNT_W'(1024);
            default: v = CNT_W'(4096);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/xosc_sync.sv
module xosc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= 1'b0;
                end else begin
                    chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xosc_lf_timer.sv
module xosc_lf_timer
    import xosc_pkg::*;
(
    input  logic              lf_clk,
    input  logic              rst,
    input  logic              en_lf,
    input  logic [CODE_W-1:0] tmo_code,
    output logic              rdy_lf
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = tmo_cycles(tmo_code);

    always_ff @(posedge lf_clk) begin
        if (rst || !en_lf) begin
            cnt_q  <= '0;
            rdy_lf <= 1'b0;
        end else if (!rdy_lf) begin
            if (cnt_q >= limit) begin
                rdy_lf <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_RDY_AT_LIMIT: assert property (@(posedge lf_clk) disable iff (rst)
        rdy_lf |-> (cnt_q == limit)); // R1

    AST_RDY_NEEDS_EN: assert property (@(posedge lf_clk) disable iff (rst)
        $rose(rdy_lf) |-> $past(en_lf)); // R2
endmodule

// File: rtl/xosc_policy.sv
module xosc_policy
    import xosc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active_mode,
    input  logic       wake_evt,
    input  xosc_ctrl_t ctrl,
    input  logic       rdy_sync,
    output logic       osc_en,
    output logic       osc_rdy,
    output logic       clk_sel,
    output logic       clk_stall
);
    xosc_mode_t mode_d;
    logic       wake_pend_q, wake_pend_d;
    logic       rdy_ok, stale;
    logic       en_d, sel_d, stall_d;

    assign rdy_ok = rdy_sync & osc_en;
    assign stale  = rdy_sync & ~osc_en;

    always_comb begin
        wake_pend_d = active_mode & ctrl.wake_sel & (wake_evt | wake_pend_q);
        if (!active_mode)        mode_d = XM_OFF;
        else if (ctrl.sel_now)    mode_d = XM_SEL_NOW;
        else if (wake_pend_d)     mode_d = XM_SEL_RDY;
        else if (ctrl.start_only) mode_d = XM_START;
        else if (ctrl.sw_en)      mode_d = XM_SW;
        else                      mode_d = XM_OFF;

        en_d    = (mode_d != XM_OFF) & ~stale;
        sel_d   = (mode_d == XM_SEL_NOW) | ((mode_d == XM_SEL_RDY) & rdy_ok);
        stall_d = (mode_d == XM_SEL_NOW) & ~rdy_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_pend_q <= 1'b0;
            osc_en      <= 1'b0;
            clk_sel     <= 1'b0;
            clk_stall   <= 1'b0;
        end else begin
            wake_pend_q <= wake_pend_d;
            osc_en      <= en_d;
            clk_sel     <= sel_d;
            clk_stall   <= stall_d;
        end
    end

    assign osc_rdy = rdy_ok;

    AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (rst)
        !active_mode |=> (!osc_en && !clk_sel && !clk_stall)); // R8

    AST_STALL_WITH_SEL: assert property (@(posedge clk) disable iff (rst)
        clk_stall |-> clk_sel); // R5

    AST_SEL_NOW_WINS: assert property (@(posedge clk) disable iff (rst)
        (active_mode && ctrl.sel_now) |=> clk_sel); // R9

    AST_START_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        (active_mode && ctrl.start_only && !ctrl.sel_now && !ctrl.wake_sel) |=> !clk_sel); // R4
endmodule

// File: rtl/xosc_startup_ctrl.sv
module xosc_startup_ctrl
    import xosc_pkg::*;
(
    input  logic              hf_clk,
    input  logic              lf_clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              active_mode,
    input  logic              wake_evt,
    output logic              osc_en,
    output logic              osc_rdy,
    output logic              clk_sel,
    output logic              clk_stall
);
    xosc_ctrl_t ctrl;
    logic       rsvd_unused;
    logic       en_lf, rdy_lf, rdy_sync;

    always_comb begin
        ctrl      = xosc_ctrl_t'(ctrl_word);
        ctrl.rsvd = 1'b0;
    end
    assign rsvd_unused = ctrl_word[CTRL_W-1];

    xosc_policy u_policy (
        .clk         (hf_clk),
        .rst         (rst),
        .active_mode (active_mode),
        .wake_evt    (wake_evt),
        .ctrl        (ctrl),
        .rdy_sync    (rdy_sync),
        .osc_en      (osc_en),
        .osc_rdy     (osc_rdy),
        .clk_sel     (clk_sel),
        .clk_stall   (clk_stall)
    );

    xosc_sync #(.STAGES(SYNC_STAGES)) u_en_to_lf (
        .clk (lf_clk),
        .rst (rst),
        .d   (osc_en),
        .q   (en_lf)
    );

    xosc_lf_timer u_timer (
        .lf_clk   (lf_clk),
        .rst      (rst),
        .en_lf    (en_lf),
        .tmo_code (ctrl.tmo),
        .rdy_lf   (rdy_lf)
    );

    xosc_sync #(.STAGES(SYNC_STAGES)) u_rdy_to_hf (
        .clk (hf_clk),
        .rst (rst),
        .d   (rdy_lf),
        .q   (rdy_sync)
    );

    AST_TMO_FROZEN: assert property (@(posedge hf_clk) disable iff (rst)
        osc_en |=> $stable(ctrl_word[CODE_W-1:0])); // R3

    AST_SEL_AFTER_RDY: assert property (@(posedge hf_clk) disable iff (rst)
        (clk_sel && !clk_stall) |-> osc_rdy); // R6
endmodule

// File: tb/xosc_startup_ctrl_tb.sv
`timescale 1ns/1ps
module xosc_startup_ctrl_tb;

    localparam logic [7:0] B_RSVD  = 8'h80;
    localparam logic [7:0] B_SW    = 8'h40;
    localparam logic [7:0] B_WAKE  = 8'h20;
    localparam logic [7:0] B_NOW   = 8'h10;
    localparam logic [7:0] B_START = 8'h08;

    logic       hf_clk = 1'b0;
    logic       lf_clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ctrl_word = 8'h00;
    logic       active_mode = 1'b0;
    logic       wake_evt = 1'b0;
    logic       osc_en, osc_rdy, clk_sel, clk_stall;

    always #2.5 hf_clk = ~hf_clk;
    initial begin
        #1;
        forever #40 lf_clk = ~lf_clk;
    end

    xosc_startup_ctrl u_dut (
        .hf_clk      (hf_clk),
        .lf_clk      (lf_clk),
        .rst         (rst),
        .ctrl_word   (ctrl_word),
        .active_mode (active_mode),
        .wake_evt    (wake_evt),
        .osc_en      (osc_en),
        .osc_rdy     (osc_rdy),
        .clk_sel     (clk_sel),
        .clk_stall   (clk_stall)
    );

    typedef struct {
        string req;
        logic  en;
        logic  sel;
        logic  stall;
        logic  rdy;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    // monitor: pops expected items and compares against the outputs
    always @(negedge hf_clk) begin
        exp_t e;
        if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            n_chk++;
            if ({osc_en, clk_sel, clk_stall, osc_rdy} !== {e.en, e.sel, e.stall, e.rdy}) begin
                n_fail++;
                $display("FAIL %s: en/sel/stall/rdy got %b%b%b%b expected %b%b%b%b",
                         e.req, osc_en, clk_sel, clk_stall, osc_rdy,
                         e.en, e.sel, e.stall, e.rdy);
            end
        end
    end

    task automatic push_exp(string req, logic en, logic sel, logic stall, logic rdy);
        exp_t e;
        e.req = req; e.en = en; e.sel = sel; e.stall = stall; e.rdy = rdy;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(negedge hf_clk);
    endtask

    task automatic chk_int(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge hf_clk);
    endtask

    // count rising lf edges from osc_en rise until osc_rdy is seen
    task automatic measure(string req, int lim);
        int n = 0;
        while (n < 5000) begin
            @(posedge lf_clk);
            n++;
            @(negedge lf_clk);
            if (osc_rdy) break;
        end
        chk_int(req, n, lim + 3);
    endtask

    task automatic settle();
        repeat (8) @(posedge lf_clk);
        @(negedge hf_clk);
    endtask

    task automatic final_report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge hf_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        final_report();
    end

    initial begin
        tick(50);
        push_exp("R12 reset state", 0, 0, 0, 0);
        drain();
        rst = 1'b0;
        tick(2);
        push_exp("R12 after release", 0, 0, 0, 0);
        drain();

        // R4 start-only, code 1 (L=2)
        ctrl_word = B_START | 8'd1; active_mode = 1'b1;
        tick(1);
        push_exp("R4 start-only enable", 1, 0, 0, 0);
        measure("R1 code1 latency", 2);
        push_exp("R4 start-only ready no select", 1, 0, 0, 1);
        drain();

        // R8 deep sleep
        active_mode = 1'b0;
        tick(1);
        push_exp("R8 deep sleep off", 0, 0, 0, 0);
        drain();
        settle();

        // R10 reserved bit alone does nothing
        ctrl_word = B_RSVD | 8'd0; active_mode = 1'b1;
        tick(3);
        push_exp("R10 reserved ignored", 0, 0, 0, 0);
        drain();

        // R5 select-now, code 0, with reserved bit set as well
        ctrl_word = B_RSVD | B_NOW | 8'd0;
        tick(1);
        push_exp("R5 select-now stall", 1, 1, 1, 0);
        measure("R2 code0 latency", 0);
        tick(2);
        push_exp("R5 stall released", 1, 1, 0, 1);
        drain();

        // R11 switch policy live
        ctrl_word = B_START | 8'd0;
        tick(1);
        push_exp("R11 live switch to start-only", 1, 0, 0, 1);
        drain();

        // R8 clearing every source
        ctrl_word = 8'd0;
        tick(1);
        push_exp("R8 all sources clear", 0, 0, 0, 0);
        drain();
        settle();

        // R6 wake ignored while its bit is clear
        ctrl_word = 8'd2;
        wake_evt = 1'b1; tick(1); wake_evt = 1'b0;
        tick(2);
        push_exp("R6 wake without arm ignored", 0, 0, 0, 0);
        drain();

        // R6 select-when-ready, code 2 (L=4)
        ctrl_word = B_WAKE | 8'd2;
        tick(3);
        push_exp("R6 armed but no event", 0, 0, 0, 0);
        drain();
        wake_evt = 1'b1; tick(1); wake_evt = 1'b0;
        push_exp("R6 wake starts no select", 1, 0, 0, 0);
        measure("R1 code2 latency", 4);
        tick(2);
        push_exp("R6 select after ready", 1, 1, 0, 1);
        drain();
        active_mode = 1'b0;
        tick(1);
        push_exp("R8 sleep drops wake select", 0, 0, 0, 0);
        drain();
        active_mode = 1'b1;
        tick(3);
        push_exp("R8 wake latch cleared", 0, 0, 0, 0);
        drain();
        settle();

        // R9 priority, code 1
        ctrl_word = B_SW | B_START | B_WAKE | B_NOW | 8'd1;
        wake_evt = 1'b1; tick(1); wake_evt = 1'b0;
        push_exp("R9 select-now wins", 1, 1, 1, 0);
        measure("R1 code1 repeat", 2);
        tick(2);
        push_exp("R9 select-now ready", 1, 1, 0, 1);
        drain();
        ctrl_word = B_SW | B_START | B_WAKE | 8'd1;
        tick(1);
        push_exp("R9 wake over start-only", 1, 1, 0, 1);
        drain();
        ctrl_word = B_SW | B_START | 8'd1;
        tick(1);
        push_exp("R9 start-only over sw", 1, 0, 0, 1);
        drain();
        ctrl_word = B_SW | 8'd1;
        tick(1);
        push_exp("R7 sw enable keeps ready", 1, 0, 0, 1);
        drain();
        ctrl_word = 8'd1;
        tick(1);
        push_exp("R8 clear after priority", 0, 0, 0, 0);
        drain();
        settle();

        // R7 software enable, code 3 (L=16)
        ctrl_word = B_SW | 8'd3;
        tick(1);
        push_exp("R7 sw enable only", 1, 0, 0, 0);
        measure("R1 code3 latency", 16);
        push_exp("R7 sw ready no select", 1, 0, 0, 1);
        drain();
        active_mode = 1'b0;
        tick(1);
        push_exp("R8 sleep overrides sw", 0, 0, 0, 0);
        drain();
        settle();

        // longer codes via start-only
        for (int c = 4; c < 8; c++) begin
            int lim;
            lim = (c == 4) ? 32 : (c == 5) ? 64 : (c == 6) ? 1024 : 4096;
            ctrl_word = B_START | 8'(c); active_mode = 1'b1;
            tick(1);
            measure($sformatf("R1 code%0d latency", c), lim);
            ctrl_word = 8'(c);
            tick(1);
            push_exp("R8 off after long code", 0, 0, 0, 0);
            drain();
            settle();
        end

        drain();
        final_report();
    end

endmodule